// File: doc/BRIEF.md
# Memory-Card Host Control and Interrupt Register Front End

This block is the register-side front end of a memory-card host controller. Software reaches it over a simple single-cycle bus (valid, write, word address, write data, combinational read data). It keeps the controller's configuration: clock divider, response and read timeouts, block length, block count, command index, a 32-bit command argument and the command/data configuration word. All of these are presented as plain outputs to the command engine and the data path, which sit outside this block.

It also decides when a command is sent. Writing the configuration word records a pending command. That command goes out as a one-cycle launch pulse either at once, if the card clock is already running, or later, when the clock is started. A stop-transfer bit in the configuration word holds the command back. Stopping the clock or rewriting the configuration emits a one-cycle abort pulse.

Single-cycle event inputs from the engine and FIFOs set interrupt request bits. A mask selects which of these reach the CPU interrupt line. When DMA is enabled, the receive and transmit FIFO requests drive two DMA request lines instead of the CPU line.

Top module: `cardhost_ctl`

## Requirements
- R1: After reset every register, the clock-enabled state, the pending flag and all request bits are zero, and the outputs irq_o, launch_o and abort_o are low. A read of an unmapped word address (13 to 15) returns zero. A write to an unmapped address changes no register.
- R2: The word address map is: 0 clock control, 1 status, 2 configuration, 3 clock divider (3 bits), 4 response timeout (7 bits), 5 read timeout (16 bits), 6 block length (12 bits), 7 block count (16 bits), 8 interrupt mask (13 bits), 9 interrupt request, 10 command index (6 bits), 11 argument high half, 12 argument low half. A write keeps only the field's width. The configuration register keeps only the bits under mask 0x3dff. A read of address 10 returns the index ORed with 0x40. Address 0 reads zero.
- R3: A write to address 11 or 12 loads bits 15:0 of the write data into the upper or lower 16 bits of the argument and leaves the other half unchanged.
- R4: Writing clock control with bit 1 set and bit 0 clear does three things: it sets status bit 8 (clock enabled), it clears request bit 4 (clock off), and, if a command is pending and configuration bit 10 (stop transfer) is clear, it launches that command. A launch is a launch_o pulse in the cycle after the write, and it clears the pending flag.
- R5: Writing clock control with bit 0 set clears status bit 8, sets request bit 4 and pulses abort_o in the next cycle. This holds even when bit 1 is also set, so stop wins over start.
- R6: A write to the configuration register marks a command pending and pulses abort_o. If the written bit 10 is clear and the clock is already enabled, it also pulses launch_o in the same cycle and leaves nothing pending.
- R7: irq_o is high while any request bit is set whose mask bit is clear. Writing address 9 clears each request bit written as 1.
- R8: While configuration bit 7 (DMA enable) is set, request bits 5 (receive) and 6 (transmit) are excluded from irq_o and drive dma_rx_req_o and dma_tx_req_o. While bit 7 is clear, both DMA lines are low.
- R9: A high bit of evt_i sets the matching request bit at the next clock edge. This takes priority over a clear of that bit in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid_i | input | 1 | Bus access this cycle |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 4 | Word address |
| bus_wdata_i | input | 32 | Write data |
| evt_i | input | 13 | Single-cycle event pulses setting request bits |
| rd_data_o | output | 32 | Read data, valid in the access cycle |
| irq_o | output | 1 | CPU interrupt |
| dma_rx_req_o | output | 1 | Receive DMA request |
| dma_tx_req_o | output | 1 | Transmit DMA request |
| launch_o | output | 1 | Command launch pulse |
| abort_o | output | 1 | Transfer abort pulse |
| clk_en_o | output | 1 | Card clock enabled |
| cfg_o | output | 14 | Command/data configuration |
| clk_div_o | output | 3 | Clock divider |
| rsp_tmo_o | output | 7 | Response timeout |
| rd_tmo_o | output | 16 | Read timeout |
| blk_len_o | output | 12 | Block length |
| blk_cnt_o | output | 16 | Block count |
| cmd_idx_o | output | 6 | Command index |
| cmd_arg_o | output | 32 | Command argument |

## Verification
The bench writes a configuration while the clock is off and checks that no launch happens. It then starts the clock and expects exactly one launch, and none on a second start. A design that forgot to clear the pending flag would launch twice, and one that ignored the stop bit would launch a held command. It writes start and stop together: a design that gave start priority would leave the clock enabled. It fires an event in the same cycle as a write-1-to-clear, where a design with the wrong priority loses the event. It also switches DMA enable with a FIFO request already set, where a design that did not route the request would raise the CPU interrupt or leave the DMA lines dead.

// File: rtl/cardhost_pkg.sv
package cardhost_pkg;
   localparam int unsigned A_CLKCTL = 0;
   localparam int unsigned A_STATUS = 1;
   localparam int unsigned A_CFG    = 2;
   localparam int unsigned A_CLKDIV = 3;
   localparam int unsigned A_RSPTMO = 4;
   localparam int unsigned A_RDTMO  = 5;
   localparam int unsigned A_BLKLEN = 6;
   localparam int unsigned A_BLKCNT = 7;
   localparam int unsigned A_IMASK  = 8;
   localparam int unsigned A_IREQ   = 9;
   localparam int unsigned A_CMDIDX = 10;
   localparam int unsigned A_ARGHI  = 11;
   localparam int unsigned A_ARGLO  = 12;

   localparam int unsigned CTL_STOP_B  = 0;
   localparam int unsigned CTL_START_B = 1;
   localparam int unsigned STS_CLKON_B = 8;
   localparam int unsigned CFG_DMA_B   = 7;
   localparam int unsigned CFG_HOLD_B  = 10;
   localparam int unsigned IRQ_CLKOFF_B = 4;
   localparam int unsigned IRQ_RX_B     = 5;
   localparam int unsigned IRQ_TX_B     = 6;

   localparam logic [31:0] CFG_KEEP = 32'h0000_3dff;
   localparam logic [31:0] CMD_TAG  = 32'h0000_0040;
endpackage

// File: rtl/ch_field_reg.sv
module ch_field_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (W < 1) begin : g_bad_w
      $error("ch_field_reg: W must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= d;
   end
endmodule

// File: rtl/ch_launch_ctl.sv
module ch_launch_ctl (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ctl_wr,
   input  logic [1:0] ctl_bits,
   input  logic       cfg_wr,
   input  logic       hold_new,
   input  logic       hold_cur,
   output logic       clk_en,
   output logic       start_ev,
   output logic       stop_ev,
   output logic       launch,
   output logic       abort
);
   import cardhost_pkg::*;

   logic pend_q;
   logic launch_d;

   assign stop_ev  = ctl_wr & ctl_bits[CTL_STOP_B];
   assign start_ev = ctl_wr & ctl_bits[CTL_START_B] & ~ctl_bits[CTL_STOP_B];

   assign launch_d = (cfg_wr & ~hold_new & clk_en) |
                     (start_ev & pend_q & ~hold_cur);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         clk_en <= 1'b0;
         pend_q <= 1'b0;
         launch <= 1'b0;
         abort  <= 1'b0;
      end else begin
         launch <= launch_d;
         abort  <= cfg_wr | stop_ev;
         if (stop_ev)       clk_en <= 1'b0;
         else if (start_ev) clk_en <= 1'b1;
         if (launch_d)      pend_q <= 1'b0;
         else if (cfg_wr)   pend_q <= 1'b1;
      end
   end

   // R4
   launch_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      launch |-> (clk_en && !pend_q));

   // R5
   stop_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(clk_en) |-> abort);
endmodule

// File: rtl/ch_irq_unit.sv
module ch_irq_unit #(
   parameter int NUM_IRQ  = 13,
   parameter bit REG_IRQ  = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_IRQ-1:0] evt,
   input  logic [NUM_IRQ-1:0] set_vec,
   input  logic [NUM_IRQ-1:0] clr_vec,
   input  logic [NUM_IRQ-1:0] mask,
   input  logic               dma_en,
   output logic [NUM_IRQ-1:0] req,
   output logic               irq,
   output logic               dma_rx,
   output logic               dma_tx
);
   import cardhost_pkg::*;

   if (NUM_IRQ <= IRQ_TX_B) begin : g_bad_n
      $error("ch_irq_unit: NUM_IRQ too small for FIFO request bits");
   end

   localparam logic [NUM_IRQ-1:0] FIFO_BITS =
      NUM_IRQ'((1 << IRQ_RX_B) | (1 << IRQ_TX_B));

   logic [NUM_IRQ-1:0] eff_mask;
   logic               irq_any;

   always_ff @(posedge clk) begin
      if (!rst_n) req <= '0;
      else        req <= (req & ~clr_vec) | set_vec | evt;
   end

   assign eff_mask = dma_en ? (mask | FIFO_BITS) : mask;
   assign irq_any  = |(req & ~eff_mask);
   assign dma_rx   = dma_en & req[IRQ_RX_B];
   assign dma_tx   = dma_en & req[IRQ_TX_B];

   if (REG_IRQ) begin : g_irq_reg
      always_ff @(posedge clk) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= irq_any;
      end
   end else begin : g_irq_comb
      assign irq = irq_any;
   end

   // R9
   evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt) |=> ((req & $past(evt)) == $past(evt)));

   // R8
   dma_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dma_en |-> (!dma_rx && !dma_tx));
endmodule

// File: rtl/cardhost_ctl.sv
module cardhost_ctl #(
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 4,
   parameter int NUM_IRQ  = 13,
   parameter int CFG_W    = 14,
   parameter int CLKDIV_W = 3,
   parameter int RSPTMO_W = 7,
   parameter int RDTMO_W  = 16,
   parameter int BLKLEN_W = 12,
   parameter int BLKCNT_W = 16,
   parameter int CMD_W    = 6,
   parameter int ARG_W    = 32,
   parameter bit REG_IRQ  = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_valid_i,
   input  logic                bus_write_i,
   input  logic [ADDR_W-1:0]   bus_addr_i,
   input  logic [DATA_W-1:0]   bus_wdata_i,
   input  logic [NUM_IRQ-1:0]  evt_i,
   output logic [DATA_W-1:0]   rd_data_o,
   output logic                irq_o,
   output logic                dma_rx_req_o,
   output logic                dma_tx_req_o,
   output logic                launch_o,
   output logic                abort_o,
   output logic                clk_en_o,
   output logic [CFG_W-1:0]    cfg_o,
   output logic [CLKDIV_W-1:0] clk_div_o,
   output logic [RSPTMO_W-1:0] rsp_tmo_o,
   output logic [RDTMO_W-1:0]  rd_tmo_o,
   output logic [BLKLEN_W-1:0] blk_len_o,
   output logic [BLKCNT_W-1:0] blk_cnt_o,
   output logic [CMD_W-1:0]    cmd_idx_o,
   output logic [ARG_W-1:0]    cmd_arg_o
);
   import cardhost_pkg::*;

   localparam int HALF_W = ARG_W / 2;
   localparam int FLD_N  = 7;
   localparam int FLD_MW = 16;

   if (DATA_W != 32)                 begin : g_bad_dw  $error("DATA_W must be 32"); end
   if (ARG_W % 2 != 0 || HALF_W > DATA_W) begin : g_bad_aw $error("bad ARG_W"); end
   if (CFG_W <= CFG_HOLD_B || CFG_W > 14) begin : g_bad_cw $error("bad CFG_W"); end
   if (CMD_W > 6)                    begin : g_bad_cmd $error("CMD_W above tag bit"); end
   if (NUM_IRQ > FLD_MW || NUM_IRQ <= IRQ_TX_B) begin : g_bad_ni $error("bad NUM_IRQ"); end
   if ((1 << ADDR_W) <= A_ARGLO)     begin : g_bad_ad  $error("ADDR_W too small"); end

   function automatic int fld_w(input int i);
      case (i)
         0: return CLKDIV_W;
         1: return RSPTMO_W;
         2: return RDTMO_W;
         3: return BLKLEN_W;
         4: return BLKCNT_W;
         5: return NUM_IRQ;
         default: return CMD_W;
      endcase
   endfunction

   function automatic int unsigned fld_a(input int i);
      case (i)
         0: return A_CLKDIV;
         1: return A_RSPTMO;
         2: return A_RDTMO;
         3: return A_BLKLEN;
         4: return A_BLKCNT;
         5: return A_IMASK;
         default: return A_CMDIDX;
      endcase
   endfunction

   logic              wr, rd;
   logic [FLD_MW-1:0] fld_q [FLD_N];
   logic [CFG_W-1:0]  cfg_q;
   logic [ARG_W-1:0]  arg_q;
   logic [NUM_IRQ-1:0] req, set_vec, clr_vec;
   logic              start_ev, stop_ev;
   logic              wr_cfg, wr_ctl, wr_ireq;
   logic              unused_bits;

   assign wr      = bus_valid_i &  bus_write_i;
   assign rd      = bus_valid_i & ~bus_write_i;
   assign wr_cfg  = wr && (bus_addr_i == ADDR_W'(A_CFG));
   assign wr_ctl  = wr && (bus_addr_i == ADDR_W'(A_CLKCTL));
   assign wr_ireq = wr && (bus_addr_i == ADDR_W'(A_IREQ));
   assign unused_bits = ^bus_wdata_i;

   for (genvar i = 0; i < FLD_N; i++) begin : g_fld
      localparam int FW = fld_w(i);
      logic [FW-1:0] q_w;
      ch_field_reg #(.W(FW)) u_fld (
         .clk (clk),
         .rst_n (rst_n),
         .we  (wr && (bus_addr_i == ADDR_W'(fld_a(i)))),
         .d   (bus_wdata_i[FW-1:0]),
         .q   (q_w)
      );
      assign fld_q[i] = FLD_MW'(q_w);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q <= '0;
         arg_q <= '0;
      end else if (wr) begin
         if (bus_addr_i == ADDR_W'(A_CFG))
            cfg_q <= bus_wdata_i[CFG_W-1:0] & CFG_KEEP[CFG_W-1:0];
         if (bus_addr_i == ADDR_W'(A_ARGHI))
            arg_q[ARG_W-1:HALF_W] <= bus_wdata_i[HALF_W-1:0];
         if (bus_addr_i == ADDR_W'(A_ARGLO))
            arg_q[HALF_W-1:0] <= bus_wdata_i[HALF_W-1:0];
      end
   end

   ch_launch_ctl u_launch (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctl_wr   (wr_ctl),
      .ctl_bits (bus_wdata_i[1:0]),
      .cfg_wr   (wr_cfg),
      .hold_new (bus_wdata_i[CFG_HOLD_B]),
      .hold_cur (cfg_q[CFG_HOLD_B]),
      .clk_en   (clk_en_o),
      .start_ev (start_ev),
      .stop_ev  (stop_ev),
      .launch   (launch_o),
      .abort    (abort_o)
   );

   always_comb begin
      set_vec = '0;
      clr_vec = wr_ireq ? bus_wdata_i[NUM_IRQ-1:0] : '0;
      if (stop_ev)  set_vec[IRQ_CLKOFF_B] = 1'b1;
      if (start_ev) clr_vec[IRQ_CLKOFF_B] = 1'b1;
   end

   ch_irq_unit #(.NUM_IRQ(NUM_IRQ), .REG_IRQ(REG_IRQ)) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt     (evt_i),
      .set_vec (set_vec),
      .clr_vec (clr_vec),
      .mask    (fld_q[5][NUM_IRQ-1:0]),
      .dma_en  (cfg_q[CFG_DMA_B]),
      .req     (req),
      .irq     (irq_o),
      .dma_rx  (dma_rx_req_o),
      .dma_tx  (dma_tx_req_o)
   );

   always_comb begin
      rd_data_o = '0;
      if (rd) begin
         case (int'(bus_addr_i))
            A_STATUS: rd_data_o[STS_CLKON_B] = clk_en_o;
            A_CFG:    rd_data_o = DATA_W'(cfg_q);
            A_CLKDIV: rd_data_o = DATA_W'(fld_q[0]);
            A_RSPTMO: rd_data_o = DATA_W'(fld_q[1]);
            A_RDTMO:  rd_data_o = DATA_W'(fld_q[2]);
            A_BLKLEN: rd_data_o = DATA_W'(fld_q[3]);
            A_BLKCNT: rd_data_o = DATA_W'(fld_q[4]);
            A_IMASK:  rd_data_o = DATA_W'(fld_q[5]);
            A_IREQ:   rd_data_o = DATA_W'(req);
            A_CMDIDX: rd_data_o = DATA_W'(fld_q[6]) | CMD_TAG;
            A_ARGHI:  rd_data_o = DATA_W'(arg_q[ARG_W-1:HALF_W]);
            A_ARGLO:  rd_data_o = DATA_W'(arg_q[HALF_W-1:0]);
            default:  rd_data_o = '0;
         endcase
      end
   end

   assign cfg_o     = cfg_q;
   assign clk_div_o = fld_q[0][CLKDIV_W-1:0];
   assign rsp_tmo_o = fld_q[1][RSPTMO_W-1:0];
   assign rd_tmo_o  = fld_q[2][RDTMO_W-1:0];
   assign blk_len_o = fld_q[3][BLKLEN_W-1:0];
   assign blk_cnt_o = fld_q[4][BLKCNT_W-1:0];
   assign cmd_idx_o = fld_q[6][CMD_W-1:0];
   assign cmd_arg_o = arg_q;

   // R5
   clkoff_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(clk_en_o) |-> req[IRQ_CLKOFF_B]);

   // R3
   arg_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && bus_addr_i == ADDR_W'(A_ARGHI)) |=>
         (arg_q[HALF_W-1:0] == $past(arg_q[HALF_W-1:0])));

   // R6
   cfg_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cfg |=> abort_o);
endmodule

// File: tb/tb_cardhost_ctl.sv
`timescale 1ns/1ps
module tb_cardhost_ctl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid_i = 1'b0, bus_write_i = 1'b0;
   logic [3:0]  bus_addr_i = '0;
   logic [31:0] bus_wdata_i = '0;
   logic [12:0] evt_i = '0;
   logic [31:0] rd_data_o;
   logic        irq_o, dma_rx_req_o, dma_tx_req_o, launch_o, abort_o, clk_en_o;
   logic [13:0] cfg_o;
   logic [2:0]  clk_div_o;
   logic [6:0]  rsp_tmo_o;
   logic [15:0] rd_tmo_o;
   logic [11:0] blk_len_o;
   logic [15:0] blk_cnt_o;
   logic [5:0]  cmd_idx_o;
   logic [31:0] cmd_arg_o;

   int nvec = 0, nerr = 0;
   logic lst_launch, lst_abort;
   logic [31:0] rv;

   always #2.5 clk = ~clk;

   cardhost_ctl dut (.*);

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nvec++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_valid_i = 1'b1; bus_write_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
      @(posedge clk); #1;
      lst_launch = launch_o; lst_abort = abort_o;
      bus_valid_i = 1'b0; bus_write_i = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_valid_i = 1'b1; bus_write_i = 1'b0; bus_addr_i = a;
      #1 d = rd_data_o;
      bus_valid_i = 1'b0;
   endtask

   task automatic fire(input logic [12:0] e);
      @(negedge clk); evt_i = e;
      @(negedge clk); evt_i = '0;
   endtask

   task automatic t_reset;
      for (int a = 0; a < 16; a++) begin
         rd(4'(a), rv); chk("R1 reset read", rv, (a == 10) ? 32'h40 : 32'h0);
      end
      chk("R1 reset irq", {29'd0, irq_o, launch_o, abort_o}, 32'h0);
   endtask

   task automatic t_widths;
      wr(3, '1); wr(4, '1); wr(5, '1); wr(6, '1); wr(7, '1); wr(8, '1); wr(10, '1);
      wr(2, '1);
      chk("R6 cfg hold no launch", {31'd0, lst_launch}, 0);
      chk("R6 cfg abort", {31'd0, lst_abort}, 1);
      rd(2, rv);  chk("R2 cfg mask", rv, 32'h3dff);
      rd(3, rv);  chk("R2 clkdiv", rv, 32'h7);
      rd(4, rv);  chk("R2 rsptmo", rv, 32'h7f);
      rd(5, rv);  chk("R2 rdtmo", rv, 32'hffff);
      rd(6, rv);  chk("R2 blklen", rv, 32'hfff);
      rd(7, rv);  chk("R2 blkcnt", rv, 32'hffff);
      rd(8, rv);  chk("R2 imask", rv, 32'h1fff);
      rd(10, rv); chk("R2 cmd tag", rv, 32'h7f);
      rd(0, rv);  chk("R2 clkctl reads zero", rv, 0);
   endtask

   task automatic t_arg;
      wr(11, 32'hffff_1234); wr(12, 32'h0000_abcd);
      chk("R3 arg both", cmd_arg_o, 32'h1234_abcd);
      wr(11, 32'h5555);
      chk("R3 hi keeps lo", cmd_arg_o, 32'h5555_abcd);
      wr(12, 32'h0001);
      chk("R3 lo keeps hi", cmd_arg_o, 32'h5555_0001);
      rd(11, rv); chk("R3 read hi", rv, 32'h5555);
   endtask

   task automatic t_unmapped;
      wr(15, '1); wr(13, '1);
      rd(15, rv); chk("R1 unmapped read", rv, 0);
      rd(13, rv); chk("R1 unmapped read 13", rv, 0);
      chk("R1 unmapped no arg change", cmd_arg_o, 32'h5555_0001);
      rd(8, rv);  chk("R1 unmapped no mask change", rv, 32'h1fff);
   endtask

   task automatic t_deferred;
      wr(2, 32'h41);
      chk("R6 clock off no launch", {31'd0, lst_launch}, 0);
      wr(0, 32'h2);
      chk("R4 start launches pending", {31'd0, lst_launch}, 1);
      rd(1, rv); chk("R4 status clk on", rv, 32'h100);
      wr(0, 32'h2);
      chk("R4 pending consumed", {31'd0, lst_launch}, 0);
   endtask

   task automatic t_immediate;
      wr(2, 32'h0);
      chk("R6 immediate launch", {30'd0, lst_launch, lst_abort}, 32'h3);
      wr(2, 32'h400);
      chk("R6 hold blocks launch", {31'd0, lst_launch}, 0);
      wr(0, 32'h2);
      chk("R4 hold blocks start launch", {31'd0, lst_launch}, 0);
   endtask

   task automatic t_stop;
      wr(8, 0); wr(9, 32'h1fff);
      wr(0, 32'h1);
      chk("R5 stop abort", {31'd0, lst_abort}, 1);
      rd(1, rv); chk("R5 status off", rv, 0);
      rd(9, rv); chk("R5 clkoff req", rv, 32'h10);
      chk("R7 irq from clkoff", {31'd0, irq_o}, 1);
   endtask

   task automatic t_mask;
      wr(9, 32'h1fff);
      chk("R7 w1c irq low", {31'd0, irq_o}, 0);
      wr(8, 32'h4); fire(13'h4);
      rd(9, rv); chk("R9 event sets", rv, 32'h4);
      chk("R7 masked no irq", {31'd0, irq_o}, 0);
      wr(8, 0);
      chk("R7 unmasked irq", {31'd0, irq_o}, 1);
      wr(9, 32'h4);
      chk("R7 w1c clears", {31'd0, irq_o}, 0);
   endtask

   task automatic t_dma;
      wr(2, 32'h480);
      fire(13'h20);
      chk("R8 rx to dma", {29'd0, irq_o, dma_rx_req_o, dma_tx_req_o}, 32'h2);
      fire(13'h40);
      chk("R8 tx to dma", {29'd0, irq_o, dma_rx_req_o, dma_tx_req_o}, 32'h3);
      wr(2, 32'h400);
      chk("R8 dma off to irq", {29'd0, irq_o, dma_rx_req_o, dma_tx_req_o}, 32'h4);
      wr(9, 32'h1fff);
   endtask

   task automatic t_priority;
      @(negedge clk);
      bus_valid_i = 1'b1; bus_write_i = 1'b1; bus_addr_i = 9; bus_wdata_i = 32'h100;
      evt_i = 13'h100;
      @(posedge clk); #1;
      bus_valid_i = 1'b0; bus_write_i = 1'b0; evt_i = '0;
      rd(9, rv); chk("R9 event beats clear", rv, 32'h100);
      wr(9, 32'h100);
      rd(9, rv); chk("R9 later clear works", rv, 0);
   endtask

   task automatic t_both;
      wr(0, 32'h2);
      rd(1, rv); chk("R4 restart status", rv, 32'h100);
      wr(0, 32'h3);
      chk("R5 both no launch, abort", {30'd0, lst_launch, lst_abort}, 32'h1);
      rd(1, rv); chk("R5 stop wins", rv, 0);
      rd(9, rv); chk("R5 both sets clkoff", rv, 32'h10);
      wr(0, 32'h2);
      rd(9, rv); chk("R4 start clears clkoff", rv, 0);
   endtask

   initial begin
      #(5.0 * 100000);
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset; t_widths; t_arg; t_unmapped; t_deferred; t_immediate;
      t_stop; t_mask; t_dma; t_priority; t_both;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end
endmodule